// File: doc/BRIEF.md
# Configuration Port Key Gate

This block guards a small legacy configuration space that a host reaches over an 8-bit I/O bus through two adjacent port addresses: an index port and a data port. After reset the space is sealed. The host opens it by writing a fixed four-byte unlock key to the index port, one byte at a time. Once it is open, the host writes a register number to the index port and then reads or writes that register through the data port.

A handful of global registers sit below offset 0x30. One selects which device bank is visible. Three read-only registers give the chip identity and revision. One register, written with a particular value, seals the space again. Offsets from 0x30 upward are passed through a register window to whichever child device owns the selected bank. The child device sees the bank number, the register index, a one-cycle write strobe with its data, and a read-data return.

Top module: `sio_cfg_gate`

## Requirements
- R1: After reset the space is sealed (`cfg_unlocked` = 0), the bank number `dev_ldn` is 0x00, the latched index `dev_idx` is 0x00 and `dev_wr` is low.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index port (address 0x2E) opens the space, and `cfg_unlocked` goes high on the clock edge that accepts the fourth byte.
- R3: While the space is sealed, an index-port write that does not match the expected key byte sends the matcher back to the first byte. If that mismatching byte is 0x87, it counts as a fresh first byte. Writes to any other address do not disturb the matcher.
- R4: While the space is sealed, data-port (0x2F) writes change nothing and never raise `dev_wr`. Reads of either port return 0xFF, so a 16-bit identity read yields 0xFFFF, which is the absent-device code.
- R5: While the space is open, an index-port write latches the byte as the register index, which appears on `dev_idx` after the edge. A read of the index port returns that index.
- R6: Register 0x07 is read/write and holds the bank number, which drives `dev_ldn`. The bank number is kept when the space is sealed again.
- R7: Register 0x20 returns the high byte of the 16-bit chip ID, 0x21 returns the low byte, and 0x22 returns the revision in bits 3:0 with bits 7:4 zero. Writes to these three registers are ignored.
- R8: Writing 0x02 to register 0x02 seals the space from the next edge, after which the full key is needed again. Any other value written to 0x02 has no effect.
- R9: With the space open and the index at 0x30 or above, a data-port write raises `dev_wr` in the same cycle, with `dev_wdata` equal to the written byte. A data-port read returns `dev_rdata`. With the index below 0x30, `dev_wr` stays low.
- R10: Any other global offset below 0x30 reads as 0x00, and writes to it are ignored.
- R11: `io_rdata` is combinational. It is valid in the same cycle as `io_rd` and is 0x00 when `io_rd` is low or the address is neither port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte (combinational) |
| cfg_unlocked | output | 1 | Configuration space is open |
| dev_ldn | output | 8 | Selected device bank number |
| dev_idx | output | 8 | Latched register index presented to the child |
| dev_wr | output | 1 | Child register write strobe |
| dev_wdata | output | 8 | Child register write data |
| dev_rdata | input | 8 | Child register read data |

## Verification
The bench aims at the key matcher's restart rule. It sends a sequence that breaks on its last byte and then one that breaks with a repeated 0x87. A matcher that failed to restart, or that dropped the 0x87 as a fresh first byte, would stay sealed or open at the wrong moment. It also interleaves data-port traffic inside a key, which a matcher fed by both ports would reject. The relock register is written with a near-miss value first, which a loose decoder would treat as a relock. The window edge at 0x2F/0x30 and writes to the read-only identity registers are also probed: a wrong boundary would leak strobes to the child, and a writable identity register would read back the written byte.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int KEY_LEN = 4;
  localparam int STAGE_W = $clog2(KEY_LEN);

  localparam logic [7:0] REG_RELOCK  = 8'h02;
  localparam logic [7:0] RELOCK_CODE = 8'h02;
  localparam logic [7:0] REG_BANK    = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_REV     = 8'h22;
  localparam logic [7:0] DEV_BASE    = 8'h30;
  localparam logic [7:0] SEALED_READ = 8'hFF;

  // Expected unlock byte for a given position in the key.
  function automatic logic [7:0] key_byte(input logic [STAGE_W-1:0] pos);
    case (pos)
      2'd0:    key_byte = 8'h87;
      2'd1:    key_byte = 8'h01;
      default: key_byte = 8'h55;
    endcase
  endfunction

  // Matcher advance: step on a match, restart at position 1 when the
  // breaking byte is itself a valid opener, otherwise fall back to 0.
  function automatic logic [STAGE_W-1:0] key_next(input logic [STAGE_W-1:0] pos,
                                                  input logic [7:0] b);
    if (b == key_byte(pos))        key_next = STAGE_W'(pos + 1'b1);
    else if (b == key_byte('0))    key_next = STAGE_W'(1);
    else                           key_next = '0;
  endfunction

  function automatic logic is_dev_offset(input logic [7:0] idx);
    is_dev_offset = (idx >= DEV_BASE);
  endfunction

endpackage

// File: rtl/sio_key_match.sv
module sio_key_match
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_in,
  input  logic       relock,
  output logic       unlocked_o,
  output logic       key_hit_o
);

  logic [STAGE_W-1:0] stage_q;

  assign key_hit_o = key_wr && !unlocked_o &&
                     (stage_q == STAGE_W'(KEY_LEN-1)) &&
                     (key_in == key_byte(stage_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_o <= 1'b0;
      stage_q    <= '0;
    end else if (relock) begin
      unlocked_o <= 1'b0;
      stage_q    <= '0;
    end else if (key_wr && !unlocked_o) begin
      if (key_hit_o) begin
        unlocked_o <= 1'b1;
        stage_q    <= '0;
      end else begin
        stage_q <= key_next(stage_q, key_in);
      end
    end
  end

endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID  = 16'h8728,
  parameter logic [3:0]  CHIP_REV = 4'h3
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  input  logic [7:0] child_rdata,
  output logic [7:0] index_q,
  output logic [7:0] bank_q,
  output logic       relock_o,
  output logic       child_wr_o,
  output logic [7:0] cfg_rdata
);

  function automatic logic [7:0] cfg_read(input logic [7:0] idx,
                                          input logic [7:0] bank,
                                          input logic [7:0] child);
    if (is_dev_offset(idx))       cfg_read = child;
    else if (idx == REG_BANK)     cfg_read = bank;
    else if (idx == REG_ID_HI)    cfg_read = CHIP_ID[15:8];
    else if (idx == REG_ID_LO)    cfg_read = CHIP_ID[7:0];
    else if (idx == REG_REV)      cfg_read = {4'h0, CHIP_REV};
    else                          cfg_read = 8'h00;
  endfunction

  logic bank_wr;

  assign relock_o   = unlocked && dat_wr && (index_q == REG_RELOCK) && (wdata == RELOCK_CODE);
  assign bank_wr    = unlocked && dat_wr && (index_q == REG_BANK);
  assign child_wr_o = unlocked && dat_wr && is_dev_offset(index_q);
  assign cfg_rdata  = cfg_read(index_q, bank_q, child_rdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      bank_q  <= 8'h00;
    end else begin
      if (unlocked && idx_wr) index_q <= wdata;
      if (bank_wr)            bank_q  <= wdata;
    end
  end

endmodule

// File: rtl/sio_cfg_gate.sv
module sio_cfg_gate
  import sio_cfg_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h002F),
  parameter logic [15:0]     CHIP_ID    = 16'h8728,
  parameter logic [3:0]      CHIP_REV   = 4'h3
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_unlocked,
  output logic [7:0]        dev_ldn,
  output logic [7:0]        dev_idx,
  output logic              dev_wr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);

  logic       hit_index;
  logic       hit_data;
  logic       idx_wr;
  logic       dat_wr;
  logic       key_wr;
  logic       key_hit;
  logic       relock;
  logic [7:0] cfg_rdata;

  assign hit_index = (io_addr == INDEX_PORT);
  assign hit_data  = (io_addr == DATA_PORT);
  assign idx_wr    = io_wr && hit_index;
  assign dat_wr    = io_wr && hit_data;
  assign key_wr    = idx_wr && !cfg_unlocked;

  sio_key_match u_key (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_wr     (key_wr),
    .key_in     (io_wdata),
    .relock     (relock),
    .unlocked_o (cfg_unlocked),
    .key_hit_o  (key_hit)
  );

  sio_cfg_regs #(
    .CHIP_ID  (CHIP_ID),
    .CHIP_REV (CHIP_REV)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .unlocked    (cfg_unlocked),
    .idx_wr      (idx_wr),
    .dat_wr      (dat_wr),
    .wdata       (io_wdata),
    .child_rdata (dev_rdata),
    .index_q     (dev_idx),
    .bank_q      (dev_ldn),
    .relock_o    (relock),
    .child_wr_o  (dev_wr),
    .cfg_rdata   (cfg_rdata)
  );

  assign dev_wdata = io_wdata;

  always_comb begin
    io_rdata = 8'h00;
    if (io_rd) begin
      if (hit_index)     io_rdata = cfg_unlocked ? dev_idx   : SEALED_READ;
      else if (hit_data) io_rdata = cfg_unlocked ? cfg_rdata : SEALED_READ;
    end
  end

endmodule

// File: rtl/sio_cfg_gate_chk.sv
module sio_cfg_gate_chk #(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h002E),
  parameter logic [ADDR_W-1:0] DATA_PORT  = ADDR_W'(16'h002F),
  parameter logic [15:0]       CHIP_ID    = 16'h8728
)(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_unlocked,
  input logic [7:0]        dev_ldn,
  input logic [7:0]        dev_idx,
  input logic              dev_wr,
  input logic              key_hit,
  input logic              relock
);

  p_sealed_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && io_rd && (io_addr == DATA_PORT || io_addr == INDEX_PORT)) |-> (io_rdata == 8'hFF));

  p_no_strobe_sealed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_unlocked |-> !dev_wr);

  p_open_needs_last_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(key_hit && io_wr && io_addr == INDEX_PORT && io_wdata == 8'h55));

  p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && io_wr && io_addr == DATA_PORT && dev_idx == 8'h02 && io_wdata == 8'h02) |=> !cfg_unlocked);

  p_relock_only_by_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_unlocked) |-> $past(relock));

  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == DATA_PORT && cfg_unlocked) |=> $stable(dev_ldn));

  p_window_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |-> (dev_idx >= 8'h30));

  p_id_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && io_rd && io_addr == DATA_PORT && dev_idx == 8'h20) |-> (io_rdata == CHIP_ID[15:8]));

endmodule

bind sio_cfg_gate sio_cfg_gate_chk #(
  .ADDR_W     (ADDR_W),
  .INDEX_PORT (INDEX_PORT),
  .DATA_PORT  (DATA_PORT),
  .CHIP_ID    (CHIP_ID)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_addr      (io_addr),
  .io_wr        (io_wr),
  .io_rd        (io_rd),
  .io_wdata     (io_wdata),
  .io_rdata     (io_rdata),
  .cfg_unlocked (cfg_unlocked),
  .dev_ldn      (dev_ldn),
  .dev_idx      (dev_idx),
  .dev_wr       (dev_wr),
  .key_hit      (key_hit),
  .relock       (relock)
);

// File: tb/sio_cfg_gate_tb_top.sv
`timescale 1ns/1ps
module sio_cfg_gate_tb_top;

  localparam logic [15:0] IDXP = 16'h002E;
  localparam logic [15:0] DATP = 16'h002F;
  localparam logic [15:0] ID   = 16'h8728;
  localparam logic [3:0]  REV  = 4'h3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cfg_unlocked;
  logic [7:0]  dev_ldn, dev_idx, dev_wdata, dev_rdata;
  logic        dev_wr;

  always #2.5 clk = ~clk;

  assign dev_rdata = dev_idx ^ 8'h5A;

  sio_cfg_gate dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
    .dev_ldn(dev_ldn), .dev_idx(dev_idx), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string req = "R1";

  // Behavioural reference state
  int       m_pos = 0;
  bit       m_open = 0;
  bit [7:0] m_idx = 0;
  bit [7:0] m_bank = 0;
  bit [7:0] key_q[$] = '{8'h87, 8'h01, 8'h55, 8'h55};

  task automatic check(string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %02h expected %02h", req, what, got, exp);
    end
  endtask

  function automatic bit [7:0] exp_read(bit [15:0] a, bit rd);
    bit [7:0] r = 8'h00;
    if (rd && a == IDXP) r = m_open ? m_idx : 8'hFF;
    else if (rd && a == DATP) begin
      if (!m_open)             r = 8'hFF;
      else if (m_idx >= 8'h30) r = m_idx ^ 8'h5A;
      else case (m_idx)
        8'h07: r = m_bank;
        8'h20: r = ID[15:8];
        8'h21: r = ID[7:0];
        8'h22: r = {4'h0, REV};
        default: r = 8'h00;
      endcase
    end
    return r;
  endfunction

  task automatic cyc(bit [15:0] a, bit wr, bit rd, bit [7:0] d);
    bit ewr;
    @(negedge clk);
    io_addr = a; io_wr = wr; io_rd = rd; io_wdata = d;
    #1;
    ewr = m_open && wr && a == DATP && m_idx >= 8'h30;
    check("cfg_unlocked", {7'd0, cfg_unlocked}, {7'd0, m_open});
    check("dev_ldn", dev_ldn, m_bank);
    check("dev_idx", dev_idx, m_idx);
    check("dev_wr", {7'd0, dev_wr}, {7'd0, ewr});
    if (ewr) check("dev_wdata", dev_wdata, d);
    check("io_rdata", io_rdata, exp_read(a, rd));
    @(posedge clk);
    if (wr && a == IDXP) begin
      if (!m_open) begin
        if (d == key_q[m_pos]) begin
          m_pos++;
          if (m_pos == key_q.size()) begin m_open = 1; m_pos = 0; end
        end else m_pos = (d == key_q[0]) ? 1 : 0;
      end else m_idx = d;
    end else if (wr && a == DATP && m_open) begin
      if (m_idx == 8'h02 && d == 8'h02) begin m_open = 0; m_pos = 0; end
      else if (m_idx == 8'h07) m_bank = d;
    end
  endtask

  task automatic wr_idx(bit [7:0] d);  cyc(IDXP, 1, 0, d); endtask
  task automatic wr_dat(bit [7:0] d);  cyc(DATP, 1, 0, d); endtask
  task automatic rd_dat();             cyc(DATP, 0, 1, 8'h00); endtask
  task automatic idle();               cyc(16'h0000, 0, 0, 8'h00); endtask
  task automatic send_key();
    foreach (key_q[i]) wr_idx(key_q[i]);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired during %s", req);
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("reset unlocked", {7'd0, cfg_unlocked}, 8'h00);
    check("reset ldn", dev_ldn, 8'h00);
    check("reset idx", dev_idx, 8'h00);
    check("reset dev_wr", {7'd0, dev_wr}, 8'h00);
    rst_n = 1'b1;
    idle();

    // R4: sealed reads and ignored data writes
    req = "R4";
    rd_dat(); cyc(IDXP, 0, 1, 0);
    wr_idx(8'h07); wr_dat(8'h05); wr_idx(8'h40); wr_dat(8'h11);
    wr_idx(8'h20); rd_dat(); wr_idx(8'h21); rd_dat();
    // R11: read data is zero without io_rd or on another address
    req = "R11";
    cyc(DATP, 0, 0, 0); cyc(16'h0080, 0, 1, 0);

    // R3: broken keys, 0x87 restart, data-port writes in between
    req = "R3";
    wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h55); wr_idx(8'h12); idle();
    wr_idx(8'h87); wr_idx(8'h01); wr_idx(8'h87); wr_idx(8'h01);
    wr_dat(8'h33); cyc(16'h0060, 1, 0, 8'h55);
    wr_idx(8'h55); wr_idx(8'h55); idle();

    // R5: index latch and readback
    req = "R5";
    wr_idx(8'h1C); cyc(IDXP, 0, 1, 0);
    // R7: identity registers, writes ignored
    req = "R7";
    wr_idx(8'h20); rd_dat(); wr_dat(8'h00); rd_dat();
    wr_idx(8'h21); rd_dat(); wr_idx(8'h22); wr_dat(8'hFF); rd_dat();
    // R6: bank register
    req = "R6";
    wr_idx(8'h07); wr_dat(8'h05); rd_dat(); wr_dat(8'hA3); rd_dat();
    // R10: unimplemented globals
    req = "R10";
    wr_idx(8'h10); wr_dat(8'h44); rd_dat();
    // R9: child window edges
    req = "R9";
    wr_idx(8'h2F); wr_dat(8'h9C); rd_dat();
    wr_idx(8'h30); wr_dat(8'h9C); rd_dat();
    wr_idx(8'hFF); wr_dat(8'h01); rd_dat();
    // R8: near miss then relock
    req = "R8";
    wr_idx(8'h02); wr_dat(8'h01); rd_dat(); wr_dat(8'h02); idle();
    rd_dat(); wr_idx(8'h55); wr_idx(8'h55); idle();
    // R2: full key again, bank kept
    req = "R2";
    send_key(); idle();
    wr_idx(8'h07); rd_dat();
    idle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule